// File: doc/BRIEF.md
# Split-Counter DMA Channel

A single-channel DMA engine that moves units of data from a source read port to a sink write port through an internal staging buffer. The fetch side and the delivery side each keep their own remaining-unit counter. The fetch counter drops as units are taken from the source. The delivery counter drops only when a unit is accepted by the sink. While data waits in the buffer, the delivery counter lags the fetch counter. Both source and sink addresses start from programmed bases and step by one unit per transfer.

The delivery side writes in bursts. It holds data until a full burst is buffered. The only exceptions are the final tail, once every unit has been fetched, and a flush. Software starts a flush by clearing the enable bit. The channel then stops fetching and writes out whatever is held. A busy bit stays set until the buffer is empty. Software polls that bit, then reads an exact delivery count and the residue in bytes. It may then set enable again to carry on from the current counter values. When the delivery counter reaches zero, a done bit is set.

Top module: `dma_split_chan`

## Requirements
- R1: After reset, both counters, the enable bit, the flush-busy bit and the done bit are zero, and neither src_valid_o nor snk_valid_o is asserted.
- R2: Register offsets on reg_addr_i:
  - Offset 0 reads {29'b0, done, flush_busy, enable} and a write sets enable from bit 0.
  - Offset 1 reads the fetch counter; a write loads the length into both counters and clears done.
  - Offset 2 reads the delivery counter; a write sets the source base address.
  - Offset 3 reads the residue in bytes; a write sets the sink base address.
- R3: While enabled, with the fetch counter nonzero and the buffer not full, the channel requests source units at addresses that rise by 1<<XFER_SHIFT from the source base. Each accepted request decrements the fetch counter by one.
- R4: Units reach the sink in fetch order, at addresses that rise by 1<<XFER_SHIFT from the sink base. The delivery counter decrements by one on each accepted sink write and at no other time, apart from a length load.
- R5: The delivery counter is never below the fetch counter. The gap between them equals the number of units held. The two counters are equal once the buffer has drained.
- R6: While fewer than BURST units are held, with the fetch counter nonzero and no flush in progress, the sink sees no write and the delivery counter does not change. Once all units are fetched, a shorter final burst is written out.
- R7: A full buffer stops source requests. While snk_ready_i is low, snk_valid_o, snk_addr_o and snk_data_o hold their values.
- R8: Writing enable from 1 to 0 stops fetching and writes all held units to the sink. The flush-busy bit reads 1 from the cycle after that write until the buffer is empty.
- R9: Setting enable again after a flush resumes fetching from the current fetch counter and source address, with no reload.
- R10: When the delivery counter reaches zero through a sink write, done is set. No source request is made while done is set.
- R11: The residue register reads the delivery counter shifted left by XFER_SHIFT.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register offset |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for reg_addr_i |
| src_valid_o | output | 1 | Source read request |
| src_addr_o | output | ADDR_W | Source unit address |
| src_ready_i | input | 1 | Source accepts request, data valid |
| src_data_i | input | DATA_W | Source unit data |
| snk_valid_o | output | 1 | Sink write request |
| snk_addr_o | output | ADDR_W | Sink unit address |
| snk_data_o | output | DATA_W | Sink unit data |
| snk_ready_i | input | 1 | Sink accepts write |

## Verification
The bench sets the buffer depth equal to the burst size of 4. With that setting, the full-buffer stall and the fetch/delivery gap peak at exactly one burst, so a held sink shows the lag clearly. A 2-bit unit shift puts the residue register at four times the delivery count. Transfer lengths of 6, 8 and 40 produce short tails, a partial burst that is left to sit and is then flushed, and long runs under random backpressure on both ports.

// File: rtl/dma_split_pkg.sv
package dma_split_pkg;
  localparam logic [1:0] ADR_CTRL = 2'd0;
  localparam logic [1:0] ADR_LEN  = 2'd1;
  localparam logic [1:0] ADR_SRC  = 2'd2;
  localparam logic [1:0] ADR_DST  = 2'd3;

  typedef struct packed {
    logic done;
    logic flush_busy;
    logic enable;
  } ch_stat_t;
endpackage

// File: rtl/dma_stage_buf.sv
module dma_stage_buf #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 8,
  parameter int OCC_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              pop_i,
  output logic [DATA_W-1:0] head_o,
  output logic [OCC_W-1:0]  occ_o,
  output logic              full_o
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [PTR_W-1:0]  wr_ptr_q, rd_ptr_q;
  logic [OCC_W-1:0]  occ_q;

  always_ff @(posedge clk_i) begin
    if (push_i) mem_q[wr_ptr_q] <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      occ_q    <= '0;
    end else begin
      if (push_i) wr_ptr_q <= (wr_ptr_q == LAST) ? '0 : wr_ptr_q + 1'b1;
      if (pop_i)  rd_ptr_q <= (rd_ptr_q == LAST) ? '0 : rd_ptr_q + 1'b1;
      case ({push_i, pop_i})
        2'b10:   occ_q <= occ_q + 1'b1;
        2'b01:   occ_q <= occ_q - 1'b1;
        default: occ_q <= occ_q;
      endcase
    end
  end

  assign head_o = mem_q[rd_ptr_q];
  assign occ_o  = occ_q;
  assign full_o = (occ_q == OCC_W'(DEPTH));
endmodule

// File: rtl/dma_fetch_side.sv
module dma_fetch_side #(
  parameter int ADDR_W     = 32,
  parameter int CNT_W      = 16,
  parameter int XFER_SHIFT = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              full_i,
  input  logic              load_len_i,
  input  logic [CNT_W-1:0]  len_i,
  input  logic              load_base_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic              src_ready_i,
  output logic              src_valid_o,
  output logic [ADDR_W-1:0] src_addr_o,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              push_o
);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(1) << XFER_SHIFT;

  logic [CNT_W-1:0]  cnt_q;
  logic [ADDR_W-1:0] addr_q;

  assign src_valid_o = en_i && (cnt_q != '0) && !full_i;
  assign push_o      = src_valid_o && src_ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      addr_q <= '0;
    end else begin
      if (load_len_i)  cnt_q <= len_i;
      else if (push_o) cnt_q <= cnt_q - 1'b1;
      if (load_base_i) addr_q <= base_i;
      else if (push_o) addr_q <= addr_q + STEP;
    end
  end

  assign src_addr_o = addr_q;
  assign cnt_o      = cnt_q;
endmodule

// File: rtl/dma_deliver_side.sv
module dma_deliver_side #(
  parameter int ADDR_W     = 32,
  parameter int CNT_W      = 16,
  parameter int XFER_SHIFT = 2,
  parameter int BURST      = 4,
  parameter int OCC_W      = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              flush_i,
  input  logic              fetch_empty_i,
  input  logic [OCC_W-1:0]  occ_i,
  input  logic              load_len_i,
  input  logic [CNT_W-1:0]  len_i,
  input  logic              load_base_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic              snk_ready_i,
  output logic              snk_valid_o,
  output logic [ADDR_W-1:0] snk_addr_o,
  output logic              pop_o,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              done_o,
  output logic              idle_o
);
  localparam int BEAT_W = $clog2(BURST + 1);
  localparam logic [OCC_W-1:0]  BURST_OCC = OCC_W'(BURST);
  localparam logic [ADDR_W-1:0] STEP      = ADDR_W'(1) << XFER_SHIFT;

  logic [BEAT_W-1:0] beat_q, beat_load;
  logic [CNT_W-1:0]  cnt_q;
  logic [ADDR_W-1:0] addr_q;
  logic              done_q, start;

  // a burst is committed only when full, on the final tail, or on flush
  always_comb begin
    start = (beat_q == '0) && (en_i || flush_i) && (occ_i != '0) &&
            ((occ_i >= BURST_OCC) || fetch_empty_i || flush_i);
    beat_load = (occ_i >= BURST_OCC) ? BEAT_W'(BURST) : BEAT_W'(occ_i);
  end

  assign snk_valid_o = (beat_q != '0);
  assign pop_o       = snk_valid_o && snk_ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      beat_q <= '0;
      cnt_q  <= '0;
      addr_q <= '0;
      done_q <= 1'b0;
    end else begin
      if (start)      beat_q <= beat_load;
      else if (pop_o) beat_q <= beat_q - 1'b1;
      if (load_len_i) begin
        cnt_q  <= len_i;
        done_q <= 1'b0;
      end else if (pop_o) begin
        cnt_q <= cnt_q - 1'b1;
        if (cnt_q == CNT_W'(1)) done_q <= 1'b1;
      end
      if (load_base_i) addr_q <= base_i;
      else if (pop_o)  addr_q <= addr_q + STEP;
    end
  end

  assign snk_addr_o = addr_q;
  assign cnt_o      = cnt_q;
  assign done_o     = done_q;
  assign idle_o     = (beat_q == '0);
endmodule

// File: rtl/dma_split_chan.sv
module dma_split_chan
  import dma_split_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int ADDR_W     = 32,
  parameter int CNT_W      = 16,
  parameter int XFER_SHIFT = 2,
  parameter int BURST      = 4,
  parameter int DEPTH      = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [1:0]        reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  output logic              src_valid_o,
  output logic [ADDR_W-1:0] src_addr_o,
  input  logic              src_ready_i,
  input  logic [DATA_W-1:0] src_data_i,
  output logic              snk_valid_o,
  output logic [ADDR_W-1:0] snk_addr_o,
  output logic [DATA_W-1:0] snk_data_o,
  input  logic              snk_ready_i
);
  localparam int OCC_W = $clog2(DEPTH + 1);

  logic             en_q, flush_q;
  logic             wr_ctrl, wr_len, wr_src, wr_dst;
  logic             push, pop, full, deliver_idle, done;
  logic [OCC_W-1:0] occ;
  logic [CNT_W-1:0] rd_cnt, wr_cnt;
  ch_stat_t         stat;

  assign wr_ctrl = reg_we_i && (reg_addr_i == ADR_CTRL);
  assign wr_len  = reg_we_i && (reg_addr_i == ADR_LEN);
  assign wr_src  = reg_we_i && (reg_addr_i == ADR_SRC);
  assign wr_dst  = reg_we_i && (reg_addr_i == ADR_DST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q    <= 1'b0;
      flush_q <= 1'b0;
    end else begin
      if (wr_ctrl) en_q <= reg_wdata_i[0];
      if (wr_ctrl && en_q && !reg_wdata_i[0])
        flush_q <= 1'b1;
      else if (flush_q && (occ == '0) && deliver_idle)
        flush_q <= 1'b0;
    end
  end

  dma_stage_buf #(.DATA_W(DATA_W), .DEPTH(DEPTH), .OCC_W(OCC_W)) u_buf (
    .clk_i, .rst_ni,
    .push_i (push),
    .data_i (src_data_i),
    .pop_i  (pop),
    .head_o (snk_data_o),
    .occ_o  (occ),
    .full_o (full)
  );

  dma_fetch_side #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .XFER_SHIFT(XFER_SHIFT)) u_fetch (
    .clk_i, .rst_ni,
    .en_i        (en_q),
    .full_i      (full),
    .load_len_i  (wr_len),
    .len_i       (reg_wdata_i[CNT_W-1:0]),
    .load_base_i (wr_src),
    .base_i      (reg_wdata_i[ADDR_W-1:0]),
    .src_ready_i,
    .src_valid_o,
    .src_addr_o,
    .cnt_o       (rd_cnt),
    .push_o      (push)
  );

  dma_deliver_side #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .XFER_SHIFT(XFER_SHIFT),
                     .BURST(BURST), .OCC_W(OCC_W)) u_deliver (
    .clk_i, .rst_ni,
    .en_i          (en_q),
    .flush_i       (flush_q),
    .fetch_empty_i (rd_cnt == '0),
    .occ_i         (occ),
    .load_len_i    (wr_len),
    .len_i         (reg_wdata_i[CNT_W-1:0]),
    .load_base_i   (wr_dst),
    .base_i        (reg_wdata_i[ADDR_W-1:0]),
    .snk_ready_i,
    .snk_valid_o,
    .snk_addr_o,
    .pop_o         (pop),
    .cnt_o         (wr_cnt),
    .done_o        (done),
    .idle_o        (deliver_idle)
  );

  always_comb begin
    stat = '{done: done, flush_busy: flush_q, enable: en_q};
    unique case (reg_addr_i)
      ADR_CTRL: reg_rdata_o = {29'b0, stat};
      ADR_LEN:  reg_rdata_o = 32'(rd_cnt);
      ADR_SRC:  reg_rdata_o = 32'(wr_cnt);
      default:  reg_rdata_o = 32'(wr_cnt) << XFER_SHIFT;
    endcase
  end
endmodule

// File: rtl/dma_split_chan_chk.sv
module dma_split_chan_chk #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              reg_we_i,
  input logic [1:0]        reg_addr_i,
  input logic              src_valid_o,
  input logic              src_ready_i,
  input logic              snk_valid_o,
  input logic              snk_ready_i,
  input logic [ADDR_W-1:0] snk_addr_o,
  input logic [DATA_W-1:0] snk_data_o,
  input logic [CNT_W-1:0]  rd_cnt,
  input logic [CNT_W-1:0]  wr_cnt,
  input logic              done
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);
  logic len_wr;
  assign len_wr = reg_we_i && (reg_addr_i == 2'd1);

  assert_gap_order_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_cnt >= rd_cnt);

  assert_fetch_step_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src_valid_o && src_ready_i && !len_wr) |=> (rd_cnt + ONE == $past(rd_cnt)));

  assert_deliver_only_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!(snk_valid_o && snk_ready_i) && !len_wr) |=> $stable(wr_cnt));

  assert_sink_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (snk_valid_o && !snk_ready_i && !reg_we_i) |=>
      (snk_valid_o && $stable(snk_addr_o) && $stable(snk_data_o)));

  assert_no_fetch_done_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done |-> !src_valid_o);
endmodule

bind dma_split_chan dma_split_chan_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .reg_we_i    (reg_we_i),
  .reg_addr_i  (reg_addr_i),
  .src_valid_o (src_valid_o),
  .src_ready_i (src_ready_i),
  .snk_valid_o (snk_valid_o),
  .snk_ready_i (snk_ready_i),
  .snk_addr_o  (snk_addr_o),
  .snk_data_o  (snk_data_o),
  .rd_cnt      (rd_cnt),
  .wr_cnt      (wr_cnt),
  .done        (done)
);

// File: tb/dma_split_chan_tb.sv
module dma_split_chan_tb;
  localparam int BURST = 4;
  localparam int DEPTH = 4;
  localparam int CNT_W = 12;
  localparam int XS    = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        src_valid, src_ready = 1'b0;
  logic [31:0] src_addr, src_data;
  logic        snk_valid, snk_ready = 1'b0;
  logic [31:0] snk_addr, snk_data;

  always #10 clk = ~clk;

  dma_split_chan #(.DATA_W(32), .ADDR_W(32), .CNT_W(CNT_W), .XFER_SHIFT(XS),
                   .BURST(BURST), .DEPTH(DEPTH)) u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .reg_we_i(reg_we), .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .src_valid_o(src_valid), .src_addr_o(src_addr), .src_ready_i(src_ready), .src_data_i(src_data),
    .snk_valid_o(snk_valid), .snk_addr_o(snk_addr), .snk_data_o(snk_data), .snk_ready_i(snk_ready)
  );

  function automatic logic [31:0] pat(input logic [31:0] a);
    return (a * 32'h9E37) ^ 32'h5A5A_0000;
  endfunction
  assign src_data = pat(src_addr);

  int total = 0, bad = 0, snk_cnt = 0, cyc = 0;
  int src_mode = 0, snk_mode = 0;  // 0 low, 1 high, 2 random, 3 manual
  logic [15:0] lfsr = 16'hACE1;
  logic [63:0] exp_q[$];

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    #1;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    if (src_mode == 0) src_ready = 1'b0;
    else if (src_mode == 1) src_ready = 1'b1;
    else if (src_mode == 2) src_ready = lfsr[0];
    if (snk_mode == 0) snk_ready = 1'b0;
    else if (snk_mode == 1) snk_ready = 1'b1;
    else if (snk_mode == 2) snk_ready = lfsr[3];
  end

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && snk_valid && snk_ready) begin
      snk_cnt++;
      if (exp_q.size() == 0) chk("R4 unexpected sink write", {snk_addr, snk_data}, 64'h0);
      else chk("R4 sink addr/data", {snk_addr, snk_data}, exp_q.pop_front());
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      total++; bad++;
      $display("FAIL R10 watchdog act=%0d exp=<150000", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic wr_reg(input logic [1:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1;
    reg_we = 1'b0;
  endtask

  task automatic rd_reg(input logic [1:0] a, output logic [31:0] v);
    @(negedge clk);
    reg_addr = a;
    #1 v = reg_rdata;
  endtask

  task automatic plan_xfer(input logic [31:0] s, input logic [31:0] d, input int n);
    for (int k = 0; k < n; k++)
      exp_q.push_back({d + 32'(k << XS), pat(s + 32'(k << XS))});
    wr_reg(2'd2, s);
    wr_reg(2'd3, d);
    wr_reg(2'd1, 32'(n));
  endtask

  task automatic wait_done(input int limit, output logic [31:0] st);
    for (int i = 0; i < limit; i++) begin
      rd_reg(2'd0, st);
      if (st[2]) break;
    end
  endtask

  task automatic stop_chan();
    wr_reg(2'd0, 32'd0);
    repeat (5) @(posedge clk);
  endtask

  logic [31:0] v;
  int s0;

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    rd_reg(2'd0, v); chk("R1 ctrl/status", 64'(v), 64'd0);
    rd_reg(2'd1, v); chk("R1 fetch counter", 64'(v), 64'd0);
    rd_reg(2'd2, v); chk("R1 delivery counter", 64'(v), 64'd0);
    rd_reg(2'd3, v); chk("R1 residue", 64'(v), 64'd0);
    chk("R1 no requests", {62'd0, src_valid, snk_valid}, 64'd0);

    // T1: length 6, free flow, tail of 2
    src_mode = 1; snk_mode = 1;
    plan_xfer(32'h100, 32'h2000, 6);
    rd_reg(2'd1, v); chk("R2 length load fetch", 64'(v), 64'd6);
    rd_reg(2'd2, v); chk("R2 length load delivery", 64'(v), 64'd6);
    rd_reg(2'd3, v); chk("R11 residue bytes", 64'(v), 64'd24);
    wr_reg(2'd0, 32'd1);
    wait_done(200, v);
    chk("R10 done with enable", 64'(v), 64'd5);
    rd_reg(2'd1, v); chk("R5 fetch drained", 64'(v), 64'd0);
    rd_reg(2'd2, v); chk("R6 tail delivered", 64'(v), 64'd0);
    s0 = 0;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      if (src_valid) s0++;
    end
    chk("R10 no fetch after done", 64'(s0), 64'd0);
    stop_chan();

    // T2: sink held low, lag and full stall
    snk_mode = 0;
    plan_xfer(32'h400, 32'h3000, 6);
    rd_reg(2'd0, v); chk("R10 done cleared by length load", 64'(v), 64'd0);
    wr_reg(2'd0, 32'd1);
    repeat (20) @(posedge clk);
    rd_reg(2'd1, v); chk("R7 fetch stops at full buffer", 64'(v), 64'd2);
    rd_reg(2'd2, v); chk("R5 delivery lags fetch", 64'(v), 64'd6);
    chk("R7 stalled burst pending, no fetch", {62'd0, src_valid, snk_valid}, 64'd1);
    snk_mode = 1;
    wait_done(200, v);
    chk("R10 done after stall", 64'(v[2]), 64'd1);
    rd_reg(2'd1, v); chk("R5 counters equal after drain", 64'(v), 64'd0);
    stop_chan();

    // T3: partial burst held, flush, resume
    src_mode = 3; src_ready = 1'b0;
    plan_xfer(32'h800, 32'h5000, 8);
    wr_reg(2'd0, 32'd1);
    s0 = snk_cnt;
    src_ready = 1'b1;
    repeat (3) @(posedge clk);
    #1 src_ready = 1'b0;
    repeat (20) @(posedge clk);
    chk("R6 no sink write while partial", 64'(snk_cnt - s0), 64'd0);
    chk("R6 sink idle while partial", 64'(snk_valid), 64'd0);
    rd_reg(2'd1, v); chk("R3 three units fetched", 64'(v), 64'd5);
    rd_reg(2'd2, v); chk("R6 delivery counter unchanged", 64'(v), 64'd8);
    rd_reg(2'd3, v); chk("R11 residue before flush", 64'(v), 64'd32);
    wr_reg(2'd0, 32'd0);
    rd_reg(2'd0, v); chk("R8 flush busy after disable", 64'(v), 64'd2);
    for (int i = 0; i < 50; i++) begin
      rd_reg(2'd0, v);
      if (!v[1]) break;
    end
    chk("R8 flush finished", 64'(v), 64'd0);
    chk("R8 held units written", 64'(snk_cnt - s0), 64'd3);
    rd_reg(2'd2, v); chk("R8 delivery counter after flush", 64'(v), 64'd5);
    rd_reg(2'd1, v); chk("R8 no fetch while disabled", 64'(v), 64'd5);
    rd_reg(2'd3, v); chk("R11 residue after flush", 64'(v), 64'd20);
    src_mode = 1;
    wr_reg(2'd0, 32'd1);
    wait_done(200, v);
    chk("R9 resume reaches done", 64'(v[2]), 64'd1);
    chk("R9 all units delivered", 64'(snk_cnt - s0), 64'd8);
    stop_chan();

    // T4: random backpressure on both ports
    src_mode = 2; snk_mode = 2;
    plan_xfer(32'h1000, 32'h8000, 40);
    wr_reg(2'd0, 32'd1);
    wait_done(2000, v);
    chk("R7 done under backpressure", 64'(v[2]), 64'd1);
    rd_reg(2'd1, v); chk("R5 fetch zero at end", 64'(v), 64'd0);
    chk("R4 scoreboard empty", 64'(exp_q.size()), 64'd0);
    stop_chan();

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule